// File: doc/BRIEF.md
# Double-Data-Rate Output Cell

This block is the output half of a memory-interface data or strobe pin group. On each rising edge of the write clock it takes one word for each lane. A word is a low half, a high half and an enable bit. It then sends both halves out on one tri-state pin per lane, one half in each clock phase, so that every pin carries two bits per clock period. The write clock is expected to be the core clock shifted by a quarter period. Generating that clock is not part of this block.

The low half is re-timed onto the falling edge and the high half onto the next rising edge. The clock level then selects which re-timed half reaches the pin. The enable goes through two registers: one loaded on the rising edge and a second, active-low one reloaded from it on the falling edge. The pin is driven only while both registers say enable. When the enable rises, the pin therefore stays in high impedance for one extra half cycle, which gives the strobe the write preamble it needs. When the enable falls, the pin is released at once.

Top module: `ddr_out_cell`

## Requirements
- R1: `d_lo`, `d_hi` and `oe` are all sampled on the same rising edge k. The low half of that word appears on the pin during the low phase that starts at the falling edge half a cycle after k.
- R2: While `clk` is low, the pin carries the low half sampled at the latest rising edge. While `clk` is high, it carries the high half sampled one rising edge before the current one. Each word therefore leaves as the low half first, then the high half.
- R3: Every lane carries two different bits per clock period, one in each phase. Alternating patterns and random data must arrive in that order with nothing lost or repeated.
- R4: The high phase that follows the first rising edge where `oe` is sampled 1 after a 0 leaves the lane undriven (this is the preamble). Drive starts at the next falling edge.
- R5: A lane is driven (`pin_oe` = 1) only when both enable registers assert. If `oe` is sampled 0 at rising edge k, the lane is undriven from k on, with no extra half cycle.
- R6: `rst` is synchronous and active high. A rising edge with `rst` = 1 clears all data registers to 0 and disables every lane. While `rst` stays high, both phases stay undriven.
- R7: Each bit of `pin` equals `pin_q` where `pin_oe` is 1, and is high impedance ('z') where `pin_oe` is 0. `pin_q` is the phase-selected data bit.
- R8: Lanes are independent. The enable pattern of one lane does not change the data or drive state of any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock (quarter-period-shifted core clock) |
| rst | input | 1 | Synchronous reset, active high |
| d_lo | input | LANES | Half sent during the low clock phase |
| d_hi | input | LANES | Half sent during the high clock phase |
| oe | input | LANES | Per-lane enable, active high |
| pin_q | output | LANES | Phase-selected data bit before the tri-state buffer |
| pin_oe | output | LANES | 1 where the lane is driven |
| pin | output | LANES | Tri-state pin bus, 'z' when not driven |

## Verification
A stale or mis-clocked capture register shows up as a wrong bit on a driven lane within one and a half clock periods of the faulty edge. The bench compares both phases of every cycle, so it sees this at the first driven phase. A fault in the active-low enable register shows up in two ways. If it is stuck enabled, the lane drives during the preamble high phase right after the enable rises. If it is stuck disabled, the lane never drives during a low phase. Both are visible at the first burst. A phase-mapping fault swaps the two halves on every driven cycle. Random data exposes it in the first cycle after reset whose two halves differ.

// File: rtl/ddr_out_pkg.sv
package ddr_out_pkg;

  // Pin value for one lane: the high half while the clock is high,
  // the low half while it is low.
  function automatic logic phase_pick(input logic clk_lvl,
                                      input logic hi_bit,
                                      input logic lo_bit);
    return clk_lvl ? hi_bit : lo_bit;
  endfunction

  // Drive rule: the rising-edge enable must be set and the
  // active-low falling-edge enable must be clear.
  function automatic logic drive_ok(input logic en_pos,
                                    input logic en_neg_n);
    return en_pos & ~en_neg_n;
  endfunction

endpackage

// File: rtl/ddr_cap_stage.sv
module ddr_cap_stage #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d_lo,
  input  logic [LANES-1:0] d_hi,
  input  logic [LANES-1:0] oe,
  output logic [LANES-1:0] cap_lo,
  output logic [LANES-1:0] cap_hi,
  output logic [LANES-1:0] en_q
);

  // All three streams are taken on one rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo <= '0;
      cap_hi <= '0;
      en_q   <= '0;
    end else begin
      cap_lo <= d_lo;
      cap_hi <= d_hi;
      en_q   <= oe;
    end
  end

endmodule

// File: rtl/ddr_retime.sv
module ddr_retime #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] cap_lo,
  input  logic [LANES-1:0] cap_hi,
  input  logic [LANES-1:0] en_q,
  output logic [LANES-1:0] lo_neg,
  output logic [LANES-1:0] hi_pos,
  output logic [LANES-1:0] en_n_q
);

  // Low half and the active-low enable are moved to the falling edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      lo_neg <= '0;
      en_n_q <= '1;
    end else begin
      lo_neg <= cap_lo;
      en_n_q <= ~en_q;
    end
  end

  // High half waits one more rising edge.
  always_ff @(posedge clk) begin
    if (rst) hi_pos <= '0;
    else     hi_pos <= cap_hi;
  end

endmodule

// File: rtl/ddr_pin_mux.sv
module ddr_pin_mux
  import ddr_out_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic [LANES-1:0] hi_pos,
  input  logic [LANES-1:0] lo_neg,
  input  logic [LANES-1:0] en_q,
  input  logic [LANES-1:0] en_n_q,
  output logic [LANES-1:0] pin_q,
  output logic [LANES-1:0] pin_oe,
  output logic [LANES-1:0] pin
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pin_q[i]  = phase_pick(clk, hi_pos[i], lo_neg[i]);
    assign pin_oe[i] = drive_ok(en_q[i], en_n_q[i]);
    assign pin[i]    = pin_oe[i] ? pin_q[i] : 1'bz;
  end

endmodule

// File: rtl/ddr_out_cell.sv
module ddr_out_cell #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d_lo,
  input  logic [LANES-1:0] d_hi,
  input  logic [LANES-1:0] oe,
  output logic [LANES-1:0] pin_q,
  output logic [LANES-1:0] pin_oe,
  output logic [LANES-1:0] pin
);

  // Named internal events, used by the bound checker.
  logic [LANES-1:0] cap_lo, cap_hi, en_q;
  logic [LANES-1:0] lo_neg, hi_pos, en_n_q;

  ddr_cap_stage #(.LANES(LANES)) u_cap (
    .clk(clk), .rst(rst), .d_lo(d_lo), .d_hi(d_hi), .oe(oe),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .en_q(en_q)
  );

  ddr_retime #(.LANES(LANES)) u_rt (
    .clk(clk), .rst(rst), .cap_lo(cap_lo), .cap_hi(cap_hi), .en_q(en_q),
    .lo_neg(lo_neg), .hi_pos(hi_pos), .en_n_q(en_n_q)
  );

  ddr_pin_mux #(.LANES(LANES)) u_mux (
    .clk(clk), .hi_pos(hi_pos), .lo_neg(lo_neg), .en_q(en_q),
    .en_n_q(en_n_q), .pin_q(pin_q), .pin_oe(pin_oe), .pin(pin)
  );

endmodule

// File: rtl/ddr_out_cell_chk.sv
module ddr_out_cell_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] d_lo,
  input logic [LANES-1:0] d_hi,
  input logic [LANES-1:0] cap_lo,
  input logic [LANES-1:0] cap_hi,
  input logic [LANES-1:0] lo_neg,
  input logic [LANES-1:0] hi_pos,
  input logic [LANES-1:0] en_q,
  input logic [LANES-1:0] pin_oe
);

  // R1: both halves taken on the same rising edge
  a_r1_same_edge: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cap_hi == $past(d_hi) && cap_lo == $past(d_lo)));

  // R2: high half re-timed one rising edge later
  a_r2_hi_retime: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (hi_pos == $past(cap_hi)));

  // R2: low half re-timed on the falling edge
  a_r2_lo_retime: assert property (@(negedge clk) disable iff (rst)
    !rst |=> (lo_neg == $past(cap_lo)));

  // R4: the high phase right after enable rises is undriven
  a_r4_preamble: assert property (@(negedge clk) disable iff (rst)
    ((en_q & ~$past(en_q) & pin_oe) == '0));

  // R6: a reset edge clears data and disables every lane
  a_r6_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && hi_pos == '0 && cap_hi == '0 && cap_lo == '0));

endmodule

bind ddr_out_cell ddr_out_cell_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .d_lo(d_lo), .d_hi(d_hi),
  .cap_lo(cap_lo), .cap_hi(cap_hi), .lo_neg(lo_neg), .hi_pos(hi_pos),
  .en_q(en_q), .pin_oe(pin_oe)
);

// File: tb/sim_ddr_out_cell.sv
`timescale 1ns/1ps
module sim_ddr_out_cell;
  localparam int L = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [L-1:0] d_lo = '0, d_hi = '0, oe = '0;
  logic [L-1:0] pin_q, pin_oe;
  wire  [L-1:0] pin;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Model state: what was sampled at the latest and the previous rising edge.
  logic [L-1:0] c_lo = '0, c_hi = '0, c_oe = '0;
  logic [L-1:0] p_hi = '0, p_oe = '0;

  always #10 clk = ~clk; // 50 MHz

  ddr_out_cell #(.LANES(L)) u0 (
    .clk(clk), .rst(rst), .d_lo(d_lo), .d_hi(d_hi), .oe(oe),
    .pin_q(pin_q), .pin_oe(pin_oe), .pin(pin)
  );

  task automatic chk(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // One clock: apply the inputs, then check the high phase and the low phase.
  task automatic step(input logic [L-1:0] lo, input logic [L-1:0] hi,
                      input logic [L-1:0] en, input logic r);
    logic [L-1:0] eo;
    logic [L-1:0] ed;
    d_lo = lo; d_hi = hi; oe = en; rst = r;
    @(posedge clk);
    p_hi = c_hi; p_oe = c_oe;
    c_lo = r ? '0 : lo; c_hi = r ? '0 : hi; c_oe = r ? '0 : en;
    #5;
    // High phase: previous high half, drive needs enable now and before
    eo = c_oe & p_oe;
    ed = p_hi;
    chk((c_oe & ~p_oe) != '0 ? "R4 preamble oe" : (r ? "R6 reset oe" : "R5 oe high"), pin_oe, eo);
    chk("R2 high-phase data", pin_q & eo, ed & eo);
    chk("R7 pin high", pin & eo, ed & eo);
    @(negedge clk);
    #5;
    // Low phase: low half just sampled, drive needs current enable
    eo = c_oe;
    ed = c_lo;
    chk(r ? "R6 reset oe low" : "R5 oe low", pin_oe, eo);
    chk("R1 R3 low-phase data", pin_q & eo, ed & eo);
    chk("R7 pin low", pin & eo, ed & eo);
    #2;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #7;
    // R6: reset held, every lane undriven
    for (int i = 0; i < 3; i++) step('1, '1, '1, 1'b1);
    chk("R6 oe after reset", pin_oe, '0);
    // R4/R1: enable turns on, preamble then data; alternating halves (R3)
    for (int i = 0; i < 6; i++) step(8'h55, 8'hAA, '1, 1'b0);
    for (int i = 0; i < 6; i++) step(8'hAA, 8'h55, '1, 1'b0);
    // R5: immediate release
    step(8'hF0, 8'h0F, '0, 1'b0);
    step(8'h00, 8'h00, '0, 1'b0);
    // R4: single-cycle enable, only the low half drives
    step(8'hC3, 8'h3C, '1, 1'b0);
    step(8'h00, 8'hFF, '0, 1'b0);
    // R8: per-lane enables differ
    for (int i = 0; i < 20; i++) step(8'($urandom), 8'($urandom), 8'hF0 ^ 8'(i), 1'b0);
    // R6: reset in the middle of a burst
    for (int i = 0; i < 4; i++) step(8'($urandom), 8'($urandom), '1, 1'b0);
    step(8'hFF, 8'hFF, '1, 1'b1);
    step(8'hFF, 8'hFF, '1, 1'b1);
    // R3/R8: random data with random enable bursts
    for (int i = 0; i < 200; i++) begin
      logic [L-1:0] e;
      e = ((i / 5) % 3 == 0) ? '0 : 8'($urandom);
      step(8'($urandom), 8'($urandom), e, 1'b0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule